// File: doc/BRIEF.md
# Forwarded Load Value Queue with Dispatch-Time Read

In a redundant pair of cores, the core that runs ahead sends each load result, with the address it used, to the core that runs behind. This block is the in-order store for those values on the trailing side. A load takes its slot when it is decoded, so the value can be handed out when the load is dispatched. The destination register can then be written at once, without waiting for address generation. The load's computed effective address arrives later on a separate check port. It is compared with the address the leading core sent, and a difference is flagged as an error.

A slot stays allocated after its value has been dispatched. It still holds the forwarded address, and it is only returned to the free pool once the address check for its tag has completed. Slots are reclaimed oldest first. The number of values waiting for dispatch is exported so that a frequency controller can tell whether the trailing core is falling behind or running ahead.

Top module: `ldfwd_queue`

## Requirements
- R1: After reset, push_ready is 1, occupancy is 0, and disp_valid, chk_done and chk_mismatch are 0.
- R2: A push is accepted in a cycle where push_valid and push_ready are both 1. Occupancy is the count of values pushed but not yet dispatched, and it rises by one in the cycle after an accepted push.
- R3: When disp_req is 1 and occupancy is nonzero, disp_valid is 1 in the next cycle. disp_data then carries the oldest undispatched value, and disp_tag carries its slot number. Slot numbers are assigned 0, 1, 2 and so on in push order, wrapping modulo DEPTH (default 128).
- R4: When disp_req is 1 and occupancy is 0, disp_stall is 1 in the same cycle. Nothing is consumed, and disp_valid is 0 in the next cycle. A value pushed in a given cycle can be dispatched no earlier than the following cycle.
- R5: A check presents chk_valid with chk_tag and chk_addr. Two cycles later, chk_done is 1 and chk_done_tag equals that tag. chk_mismatch is 1 exactly when chk_addr differs from the address pushed with that tag.
- R6: A slot counts against capacity from its push until its address check. push_ready is 0 while DEPTH slots are held, even if every value has been dispatched. Slots are freed in tag order, so checking a newer tag frees nothing while an older tag is unchecked. push_ready returns no later than two cycles after the check that frees the oldest slot.
- R7: A cycle with both an accepted push and a dispatch leaves occupancy unchanged.
- R8: A push presented while push_ready is 0 is dropped. It does not change occupancy and is never dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Leading core offers a load value |
| push_data | input | DATA_W | Forwarded load value |
| push_addr | input | ADDR_W | Address the leading core used |
| push_ready | output | 1 | A free slot exists; push is accepted |
| disp_req | input | 1 | A load is being dispatched this cycle |
| disp_stall | output | 1 | No value available; dispatch must wait |
| disp_valid | output | 1 | disp_data/disp_tag valid (one cycle after request) |
| disp_data | output | DATA_W | Value for the destination register |
| disp_tag | output | TAG_W | Slot number of the dispatched load |
| chk_valid | input | 1 | Computed effective address is presented |
| chk_tag | input | TAG_W | Slot being checked |
| chk_addr | input | ADDR_W | Computed effective address |
| chk_done | output | 1 | Result of a check is valid |
| chk_done_tag | output | TAG_W | Slot the result belongs to |
| chk_mismatch | output | 1 | Computed and forwarded address differ |
| occupancy | output | CNT_W | Values pushed and not yet dispatched |

## Verification
Several properties are checked by assertions on every cycle:
- occupancy never exceeds the number of held slots;
- a stalled dispatch is followed by no valid output;
- push-plus-dispatch leaves occupancy steady;
- every check result has a request two cycles earlier;
- no tag is checked twice before it is freed.

Other behaviours need the bench's scenarios:
- the actual values and their program order;
- tag wrap-around;
- the address comparison outcome for matching and differing addresses;
- slot retention after dispatch;
- in-order reclamation when checks arrive out of order;
- the dropping of a push offered while full.

// File: rtl/ldfwd_pkg.sv
package ldfwd_pkg;
  localparam int unsigned DEF_DEPTH  = 128;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_ADDR_W = 32;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'b00,
    CNT_DEC  = 2'b01,
    CNT_INC  = 2'b10,
    CNT_BOTH = 2'b11
  } cnt_op_e;
endpackage

// File: rtl/ldfwd_ram.sv
module ldfwd_ram #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ldfwd_release.sv
module ldfwd_release #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned TW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mark_en,
  input  logic [TW-1:0] mark_tag,
  output logic          release_o
);
  logic [DEPTH-1:0] done_q;
  logic [TW-1:0]    fr_ptr;

  assign release_o = done_q[fr_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      fr_ptr <= '0;
    end else begin
      if (mark_en) done_q[mark_tag] <= 1'b1;
      if (release_o) begin
        done_q[fr_ptr] <= 1'b0;
        fr_ptr         <= fr_ptr + TW'(1);
      end
    end
  end

  // R5
  double_mark_chk: assert property (@(posedge clk) disable iff (rst)
    mark_en |-> !done_q[mark_tag]);
endmodule

// File: rtl/ldfwd_queue.sv
module ldfwd_queue
  import ldfwd_pkg::*;
#(
  parameter int unsigned DEPTH  = DEF_DEPTH,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic [ADDR_W-1:0] push_addr,
  output logic              push_ready,
  input  logic              disp_req,
  output logic              disp_stall,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_data,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_done,
  output logic [TAG_W-1:0]  chk_done_tag,
  output logic              chk_mismatch,
  output logic [CNT_W-1:0]  occupancy
);
  logic [TAG_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  held_cnt;
  logic              push_fire, disp_fire, rel;
  logic              s1_valid;
  logic [TAG_W-1:0]  s1_tag;
  logic [ADDR_W-1:0] s1_addr;
  logic [ADDR_W-1:0] fwd_addr;
  cnt_op_e           occ_op, held_op;

  assign push_ready = (held_cnt != CNT_W'(DEPTH));
  assign push_fire  = push_valid && push_ready;
  assign disp_stall = disp_req && (occupancy == '0);
  assign disp_fire  = disp_req && (occupancy != '0);
  assign occ_op     = cnt_op_e'({push_fire, disp_fire});
  assign held_op    = cnt_op_e'({push_fire, rel});

  // Value storage: written on push, read at dispatch.
  ldfwd_ram #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_val_ram (
    .clk(clk), .we(push_fire), .waddr(wr_ptr), .wdata(push_data),
    .re(disp_fire), .raddr(rd_ptr), .rdata(disp_data));

  // Forwarded address storage: read by tag on the later check.
  ldfwd_ram #(.DEPTH(DEPTH), .WIDTH(ADDR_W)) u_addr_ram (
    .clk(clk), .we(push_fire), .waddr(wr_ptr), .wdata(push_addr),
    .re(chk_valid), .raddr(chk_tag), .rdata(fwd_addr));

  ldfwd_release #(.DEPTH(DEPTH)) u_release (
    .clk(clk), .rst(rst), .mark_en(chk_valid), .mark_tag(chk_tag),
    .release_o(rel));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      occupancy  <= '0;
      held_cnt   <= '0;
      disp_valid <= 1'b0;
      disp_tag   <= '0;
    end else begin
      if (push_fire) wr_ptr <= wr_ptr + TAG_W'(1);
      if (disp_fire) rd_ptr <= rd_ptr + TAG_W'(1);
      disp_valid <= disp_fire;
      if (disp_fire) disp_tag <= rd_ptr;
      case (occ_op)
        CNT_INC: occupancy <= occupancy + CNT_W'(1);
        CNT_DEC: occupancy <= occupancy - CNT_W'(1);
        default: occupancy <= occupancy;
      endcase
      case (held_op)
        CNT_INC: held_cnt <= held_cnt + CNT_W'(1);
        CNT_DEC: held_cnt <= held_cnt - CNT_W'(1);
        default: held_cnt <= held_cnt;
      endcase
    end
  end

  // Address check pipeline: stage 1 aligns with the RAM read, stage 2 registers the result.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid     <= 1'b0;
      s1_tag       <= '0;
      s1_addr      <= '0;
      chk_done     <= 1'b0;
      chk_done_tag <= '0;
      chk_mismatch <= 1'b0;
    end else begin
      s1_valid <= chk_valid;
      if (chk_valid) begin
        s1_tag  <= chk_tag;
        s1_addr <= chk_addr;
      end
      chk_done     <= s1_valid;
      chk_done_tag <= s1_tag;
      chk_mismatch <= s1_valid && (s1_addr != fwd_addr);
    end
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occupancy <= held_cnt);
  // R4
  stall_empty_chk: assert property (@(posedge clk) disable iff (rst)
    disp_stall |=> !disp_valid);
  // R7
  occ_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (push_fire && disp_fire) |=> $stable(occupancy));
  // R5
  chk_latency_chk: assert property (@(posedge clk) disable iff (rst)
    chk_done |-> $past(chk_valid, 2));
  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_ready && !disp_fire) |=> $stable(occupancy));
endmodule

// File: tb/ldfwd_queue_tb.sv
module ldfwd_queue_tb;
  localparam int DEPTH = 128;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int TW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int NV = 8;

  // Vector table: forwarded value, forwarded address, computed address.
  localparam logic [DW-1:0] V_DATA [NV] = '{32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 32'h4444_0004,
                                            32'h5555_0005, 32'h6666_0006, 32'h7777_0007, 32'h8888_0008};
  localparam logic [AW-1:0] V_FADDR[NV] = '{32'h0000_1000, 32'h0000_1004, 32'h0000_2000, 32'h0000_2008,
                                            32'h0000_3000, 32'h0000_300C, 32'h0000_4000, 32'h0000_4010};
  localparam logic [AW-1:0] V_CADDR[NV] = '{32'h0000_1000, 32'h0000_1005, 32'h0000_2000, 32'h8000_2008,
                                            32'h0000_3000, 32'h0000_300C, 32'h0000_4001, 32'h0000_4010};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 1'b0, disp_req = 1'b0, chk_valid = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [AW-1:0] push_addr = '0, chk_addr = '0;
  logic [TW-1:0] chk_tag = '0;
  logic push_ready, disp_stall, disp_valid, chk_done, chk_mismatch;
  logic [DW-1:0] disp_data;
  logic [TW-1:0] disp_tag, chk_done_tag;
  logic [CW-1:0] occupancy;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ldfwd_queue #(.DEPTH(DEPTH), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .push_addr(push_addr), .push_ready(push_ready), .disp_req(disp_req),
    .disp_stall(disp_stall), .disp_valid(disp_valid), .disp_data(disp_data),
    .disp_tag(disp_tag), .chk_valid(chk_valid), .chk_tag(chk_tag),
    .chk_addr(chk_addr), .chk_done(chk_done), .chk_done_tag(chk_done_tag),
    .chk_mismatch(chk_mismatch), .occupancy(occupancy));

  task automatic expect_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_push(input logic [DW-1:0] d, input logic [AW-1:0] a);
    push_valid = 1'b1; push_data = d; push_addr = a;
    tick;
    push_valid = 1'b0;
  endtask

  task automatic do_disp(input string req, input logic [DW-1:0] d, input logic [TW-1:0] t);
    disp_req = 1'b1;
    tick;
    disp_req = 1'b0;
    expect_eq({req, " disp_valid"}, 64'(disp_valid), 64'd1);
    expect_eq({req, " disp_data"}, 64'(disp_data), 64'(d));
    expect_eq({req, " disp_tag"}, 64'(disp_tag), 64'(t));
  endtask

  task automatic do_check(input string req, input logic [TW-1:0] t, input logic [AW-1:0] a,
                          input logic mm);
    chk_valid = 1'b1; chk_tag = t; chk_addr = a;
    tick;
    chk_valid = 1'b0;
    tick;
    expect_eq({req, " chk_done"}, 64'(chk_done), 64'd1);
    expect_eq({req, " chk_done_tag"}, 64'(chk_done_tag), 64'(t));
    expect_eq({req, " chk_mismatch"}, 64'(chk_mismatch), 64'(mm));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rst = 1'b0;
    // R1 reset state
    expect_eq("R1 push_ready", 64'(push_ready), 64'd1);
    expect_eq("R1 occupancy", 64'(occupancy), 64'd0);
    expect_eq("R1 disp_valid", 64'(disp_valid), 64'd0);
    expect_eq("R1 chk_done", 64'(chk_done), 64'd0);
    expect_eq("R1 chk_mismatch", 64'(chk_mismatch), 64'd0);

    // Table walk: push all, dispatch in order, check addresses
    for (int i = 0; i < NV; i++) begin
      do_push(V_DATA[i], V_FADDR[i]);
      expect_eq("R2 occupancy after push", 64'(occupancy), 64'(i + 1));
    end
    for (int i = 0; i < NV; i++) do_disp("R3 table order", V_DATA[i], TW'(i));
    expect_eq("R3 occupancy drained", 64'(occupancy), 64'd0);
    for (int i = 0; i < NV; i++)
      do_check("R5 table", TW'(i), V_CADDR[i], V_CADDR[i] != V_FADDR[i]);

    // R4 stall on empty
    disp_req = 1'b1;
    #1;
    expect_eq("R4 disp_stall", 64'(disp_stall), 64'd1);
    tick;
    disp_req = 1'b0;
    expect_eq("R4 no disp_valid", 64'(disp_valid), 64'd0);
    expect_eq("R4 occupancy", 64'(occupancy), 64'd0);

    // R7 push and dispatch together
    do_push(32'hCAFE_0008, 32'h0000_5000);
    push_valid = 1'b1; push_data = 32'hCAFE_0009; push_addr = 32'h0000_5004;
    disp_req = 1'b1;
    tick;
    push_valid = 1'b0; disp_req = 1'b0;
    expect_eq("R7 occupancy steady", 64'(occupancy), 64'd1);
    expect_eq("R7 disp_data", 64'(disp_data), 64'h0000_0000_CAFE_0008);
    expect_eq("R7 disp_tag", 64'(disp_tag), 64'd8);
    do_disp("R3 second", 32'hCAFE_0009, TW'(9));
    do_check("R5 tag8", TW'(8), 32'h0000_5000, 1'b0);
    do_check("R5 tag9", TW'(9), 32'h0000_5004, 1'b0);
    tick;

    // R6 fill every slot, tags wrap from 10
    for (int k = 0; k < DEPTH; k++) begin
      expect_eq("R6 ready while filling", 64'(push_ready), 64'd1);
      do_push(32'hA000_0000 + 32'(k), 32'hB000_0000 + 32'(k));
    end
    expect_eq("R6 full", 64'(push_ready), 64'd0);
    for (int k = 0; k < DEPTH; k++)
      do_disp("R3 wrap", 32'hA000_0000 + 32'(k), TW'((10 + k) % DEPTH));
    expect_eq("R6 held after dispatch", 64'(push_ready), 64'd0);

    // R8 push while full is dropped
    do_push(32'hDEAD_BEEF, 32'h0);
    expect_eq("R8 occupancy unchanged", 64'(occupancy), 64'd0);

    // R6 newer tag checked first frees nothing
    do_check("R6 ooo newer", TW'(11), 32'hB000_0001, 1'b0);
    tick;
    expect_eq("R6 still full", 64'(push_ready), 64'd0);
    do_check("R6 ooo older", TW'(10), 32'hB000_0000, 1'b0);
    expect_eq("R6 freed", 64'(push_ready), 64'd1);

    do_push(32'h5EED_0001, 32'h0000_6000);
    expect_eq("R8 occupancy one", 64'(occupancy), 64'd1);
    do_disp("R8 dropped value absent", 32'h5EED_0001, TW'(10));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule